// File: doc/BRIEF.md
# Superimposed-Value Transition Detector

This block looks for the sudden change that marks the start of a power-system fault. Several measuring loops each deliver one voltage sample and one current sample per sampling strobe, at a fixed number of samples per power cycle. For every channel the block keeps the last two cycles of samples. From the sample one cycle back and the sample two cycles back it extrapolates the value expected now. The magnitude of the difference between the actual and the expected value is the superimposed (delta) value. When the network is steady and periodic, this delta stays near zero. When a fault begins, it jumps.

Each delta magnitude is compared against a current limit or a voltage limit, both supplied as input constants. A single exceedance on any channel raises a start flag and opens a decision window two cycles long. A confirmation flag follows when one loop shows both its voltage delta and its current delta above their limits on three samples in a row. Both flags hold until the window runs out, and then they drop together. Detection stays disabled while the delay lines are still filling, and a healthy-network input that is low keeps the block idle.

Top module: `transition_detector`

## Requirements
- R1: After reset, start, confirmed and window are all low.
- R2: The expected sample is twice the sample one cycle (SPC strobes) earlier minus the sample two cycles earlier. A signal that repeats exactly every cycle therefore never produces a start.
- R3: Inputs are two's complement. A channel exceeds only when the magnitude of its delta is strictly greater than its limit. A delta equal to the limit does not exceed. A negative delta of larger magnitude does exceed.
- R4: At the clock edge of a strobe on which any voltage or current channel exceeds while the block is armed and no window is open, start and window go high.
- R5: confirmed goes high at the edge of the third consecutive strobe on which the same loop has both its voltage and its current exceeding. Any strobe on which either condition fails restarts that loop's count. A voltage exceedance on one loop and a current exceedance on another never confirm.
- R6: Once opened, the window stays high for 2·SPC strobes counted from the detecting strobe. At the edge of the 2·SPC-th following strobe, start, confirmed and window all clear together, and that strobe cannot open a new window.
- R7: The block is armed only after 2·SPC strobes have been taken with healthy high, counted from reset or from the last cycle healthy was low. While healthy is low, all outputs are cleared at the next edge.
- R8: Cycles without a strobe neither shift the delay lines, advance the window, nor change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| healthy | input | 1 | Network in pre-fault healthy state; low clears and disarms |
| smp_valid | input | 1 | Sample strobe, one new sample per channel |
| v_smp | input | NLOOP*W | Voltage samples, loop l in bits l*W +: W, signed |
| i_smp | input | NLOOP*W | Current samples, loop l in bits l*W +: W, signed |
| v_thr | input | W | Voltage delta limit, unsigned |
| i_thr | input | W | Current delta limit, unsigned |
| start | output | 1 | Transition detected, held for the window |
| confirmed | output | 1 | Three-sample confirmation on one loop |
| window | output | 1 | Two-cycle high-speed decision window open |

## Verification
The bench goes after several failure modes. A delta exactly equal to its limit is used to expose a comparator that is not strict. A negative pulse is used to expose a design that ignores the sign. A pulse delivered on the last strobe before arming must be ignored, and its echo one cycle later must be caught; this catches a fill counter that is off by one. Voltage on one loop paired with current on another must not confirm, which exposes a design that pools conditions across loops. A broken run of three must also fail to confirm, which catches a counter that does not restart. Idle cycles carrying large input values are inserted in the middle of a window. A design that shifts or counts without a strobe would then close the window at the wrong strobe or report wrong deltas. The bench also checks that the flags drop on exactly the 2·SPC-th strobe and that the following strobe can detect again.

// File: rtl/transition_detector.sv
module transition_detector #(
  parameter int W     = 16,
  parameter int SPC   = 24,
  parameter int NLOOP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               healthy,
  input  logic               smp_valid,
  input  logic [NLOOP*W-1:0] v_smp,
  input  logic [NLOOP*W-1:0] i_smp,
  input  logic [W-1:0]       v_thr,
  input  logic [W-1:0]       i_thr,
  output logic               start,
  output logic               confirmed,
  output logic               window
);
  localparam int DEPTH = 2 * SPC;
  localparam int DW    = W + 3;
  localparam int FW    = $clog2(DEPTH + 1);

  function automatic logic [DW-1:0] abs_delta(input logic [W-1:0] g, input logic [W-1:0] g1,
                                              input logic [W-1:0] g2);
    logic signed [DW-1:0] d;
    d = $signed({{3{g[W-1]}}, g}) - ($signed({{3{g1[W-1]}}, g1}) <<< 1)
        + $signed({{3{g2[W-1]}}, g2});
    return d[DW-1] ? DW'(-d) : DW'(d);
  endfunction

  logic [NLOOP-1:0] vex, iex;
  logic [1:0]       cnt [NLOOP];
  logic [FW-1:0]    fill, wc;
  logic             st, cf;

  wire armed   = (fill == FW'(DEPTH));
  wire closing = (wc == FW'(1));

  for (genvar l = 0; l < NLOOP; l++) begin : g_loop
    logic [W-1:0] vd [DEPTH];
    logic [W-1:0] id [DEPTH];

    always_ff @(posedge clk) begin
      if (smp_valid) begin
        vd[0] <= v_smp[l*W +: W];
        id[0] <= i_smp[l*W +: W];
        for (int k = 1; k < DEPTH; k++) begin
          vd[k] <= vd[k-1];
          id[k] <= id[k-1];
        end
      end
    end

    assign vex[l] = abs_delta(v_smp[l*W +: W], vd[SPC-1], vd[DEPTH-1]) > {3'b000, v_thr};
    assign iex[l] = abs_delta(i_smp[l*W +: W], id[SPC-1], id[DEPTH-1]) > {3'b000, i_thr};
  end

  logic [NLOOP-1:0] hit3;
  always_comb
    for (int l = 0; l < NLOOP; l++) hit3[l] = vex[l] & iex[l] & (cnt[l] >= 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLOOP; l++) cnt[l] <= '0;
    end else begin
      for (int l = 0; l < NLOOP; l++) begin
        if (!healthy) cnt[l] <= '0;
        else if (smp_valid) begin
          if (!armed || closing || !(vex[l] & iex[l])) cnt[l] <= '0;
          else if (cnt[l] != 2'd3) cnt[l] <= cnt[l] + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      wc   <= '0;
      st   <= 1'b0;
      cf   <= 1'b0;
    end else if (!healthy) begin
      fill <= '0;
      wc   <= '0;
      st   <= 1'b0;
      cf   <= 1'b0;
    end else if (smp_valid) begin
      if (!armed) fill <= fill + FW'(1);
      if (wc != '0) begin
        if (closing) begin
          wc <= '0;
          st <= 1'b0;
          cf <= 1'b0;
        end else begin
          wc <= wc - FW'(1);
          if (|hit3) cf <= 1'b1;
        end
      end else if (armed && |(vex | iex)) begin
        st <= 1'b1;
        wc <= FW'(DEPTH);
      end
    end
  end

  assign start     = st;
  assign confirmed = cf;
  assign window    = (wc != '0);
endmodule

// File: rtl/transition_detector_chk.sv
module transition_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic healthy,
  input logic smp_valid,
  input logic start,
  input logic confirmed,
  input logic window
);
  AST_CONF_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    confirmed |-> start); // R5
  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> window); // R6
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start) |-> (!confirmed && !window)); // R6
  AST_HEALTHY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !healthy |=> (!start && !confirmed && !window)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (healthy && !smp_valid) |=> ($stable(start) && $stable(confirmed) && $stable(window))); // R8
endmodule

bind transition_detector transition_detector_chk u_chk (.*);

// File: tb/transition_detector_tb.sv
`timescale 1ns/1ps
module transition_detector_tb;
  localparam int W = 12, SPC = 4, NL = 2, DEPTH = 2 * SPC;
  localparam int VTH = 100, ITH = 50;

  logic clk = 1'b0, rst_n = 1'b0, healthy = 1'b1, smp_valid = 1'b0;
  logic [NL*W-1:0] v_smp = '0, i_smp = '0;
  logic start, confirmed, window;

  always #2.5 clk = ~clk;

  transition_detector #(.W(W), .SPC(SPC), .NLOOP(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .healthy(healthy), .smp_valid(smp_valid),
    .v_smp(v_smp), .i_smp(i_smp), .v_thr(W'(VTH)), .i_thr(W'(ITH)),
    .start(start), .confirmed(confirmed), .window(window));

  int checks = 0, errors = 0, n = 0;
  int pv [NL], pi [NL];
  int hv [NL][DEPTH], hi [NL][DEPTH], mcnt [NL];
  int mfill = 0, mwc = 0;
  bit mst = 0, mcf = 0;

  task automatic check(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (sample %0d)", req, what, got, exp, n);
    end
  endtask

  function automatic int base(input int l, input int k);
    return (k % SPC) * 23 - 40 + l * 7;
  endfunction

  function automatic int iabs(input int x);
    return x < 0 ? -x : x;
  endfunction

  task automatic model(input int cv [NL], input int ci [NL]);
    bit vx [NL], ix [NL];
    bit armed, closing, anyx, any3;
    armed = (mfill == DEPTH);
    anyx = 0; any3 = 0;
    for (int l = 0; l < NL; l++) begin
      vx[l] = iabs(cv[l] - 2 * hv[l][SPC-1] + hv[l][DEPTH-1]) > VTH;
      ix[l] = iabs(ci[l] - 2 * hi[l][SPC-1] + hi[l][DEPTH-1]) > ITH;
      anyx |= vx[l] | ix[l];
    end
    if (!healthy) begin
      mfill = 0; mwc = 0; mst = 0; mcf = 0;
      for (int l = 0; l < NL; l++) mcnt[l] = 0;
    end else begin
      closing = (mwc == 1);
      for (int l = 0; l < NL; l++) begin
        if (!armed || closing || !(vx[l] && ix[l])) mcnt[l] = 0;
        else if (mcnt[l] < 3) mcnt[l]++;
        any3 |= (mcnt[l] == 3);
      end
      if (mwc != 0) begin
        if (closing) begin mwc = 0; mst = 0; mcf = 0; end
        else begin mwc--; if (any3) mcf = 1; end
      end else if (armed && anyx) begin
        mst = 1; mwc = DEPTH;
      end
      if (mfill < DEPTH) mfill++;
    end
    for (int l = 0; l < NL; l++) begin
      for (int k = DEPTH - 1; k > 0; k--) begin
        hv[l][k] = hv[l][k-1];
        hi[l][k] = hi[l][k-1];
      end
      hv[l][0] = cv[l];
      hi[l][0] = ci[l];
    end
  endtask

  // one strobe; compares all outputs with the model afterwards (R4, R5, R6)
  task automatic step();
    int cv [NL], ci [NL];
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      cv[l] = base(l, n) + pv[l];
      ci[l] = base(l, n) + 3 + pi[l];
      v_smp[l*W +: W] = W'(cv[l]);
      i_smp[l*W +: W] = W'(ci[l]);
    end
    smp_valid = 1'b1;
    model(cv, ci);
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    n++;
    for (int l = 0; l < NL; l++) begin pv[l] = 0; pi[l] = 0; end
    check(start, mst, "R4", "start vs model");
    check(confirmed, mcf, "R5", "confirmed vs model");
    check(window, mwc != 0, "R6", "window vs model");
  endtask

  task automatic steps(input int k);
    for (int j = 0; j < k; j++) step();
  endtask

  task automatic rearm();
    healthy = 1'b0;
    step();
    healthy = 1'b1;
    steps(DEPTH);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      pv[l] = 0; pi[l] = 0; mcnt[l] = 0;
      for (int k = 0; k < DEPTH; k++) begin hv[l][k] = 0; hi[l][k] = 0; end
    end
    repeat (3) @(posedge clk);
    #1;
    check(start, 0, "R1", "reset start");
    check(confirmed, 0, "R1", "reset confirmed");
    check(window, 0, "R1", "reset window");
    rst_n = 1'b1;

    // R7: pulse on the last strobe before arming is ignored, its echo is caught
    steps(DEPTH - 1);
    pv[0] = 1500;
    step();
    check(start, 0, "R7", "pulse before armed");
    steps(SPC - 1);
    check(start, 0, "R7", "quiet after unarmed pulse");
    step();
    check(start, 1, "R7", "echo after arming");
    steps(3 * SPC);
    rearm();

    // R2: period-exact signal never starts
    steps(3 * SPC);
    check(start, 0, "R2", "periodic signal");

    // R3: equal to limit does not exceed
    pv[0] = VTH; pi[1] = -ITH;
    step();
    check(start, 0, "R3", "delta equal to limit");
    rearm();

    // R3/R4: negative delta over limit starts
    pv[1] = -(VTH + 1);
    step();
    check(start, 1, "R4", "negative delta start");
    check(window, 1, "R4", "window opens");
    rearm();

    // R5: three consecutive both-exceed on one loop
    pv[0] = 200; pi[0] = 100; step();
    pv[0] = 200; pi[0] = 100; step();
    check(confirmed, 0, "R5", "two samples not enough");
    pv[0] = 200; pi[0] = 100; step();
    check(confirmed, 1, "R5", "third sample confirms");
    rearm();

    // R5: voltage and current on different loops
    for (int j = 0; j < 3; j++) begin pv[0] = 200; pi[1] = 100; step(); end
    check(start, 1, "R5", "split loops start");
    check(confirmed, 0, "R5", "split loops no confirm");
    rearm();

    // R5: broken run
    pv[0] = 200; pi[0] = 100; step();
    pv[0] = 200; pi[0] = 100; step();
    step();
    pv[0] = 200; pi[0] = 100; step();
    check(confirmed, 0, "R5", "broken run");
    rearm();

    // R6/R8: window length with idle cycles inside
    for (int j = 0; j < 3; j++) begin pv[1] = 300; pi[1] = 150; step(); end
    check(confirmed, 1, "R6", "confirmed in window");
    @(negedge clk);
    v_smp = '1; i_smp = {NL{W'(1500)}};
    repeat (6) @(negedge clk);
    check(start, 1, "R8", "idle keeps start");
    check(window, 1, "R8", "idle keeps window");
    steps(DEPTH - 3);
    check(window, 1, "R6", "window before last strobe");
    step();
    check(start, 0, "R6", "start cleared at expiry");
    check(confirmed, 0, "R6", "confirmed cleared at expiry");
    check(window, 0, "R6", "window cleared at expiry");
    step();
    check(start, 1, "R6", "re-detect after expiry");

    // R7: healthy low clears
    healthy = 1'b0;
    step();
    check(start, 0, "R7", "healthy low clears start");
    check(window, 0, "R7", "healthy low clears window");
    healthy = 1'b1;
    steps(3 * DEPTH);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule